// File: doc/BRIEF.md
# External Multiplexed Bus Cycle Controller

This block turns code-fetch and data-access requests into cycles on an external bus that carries the address and the data on the same wires. A cycle may open with an address-latch phase. In that phase the full address is put on the bus and the `ale` strobe is raised, so that memory outside the chip can capture the upper address bits. Next comes a strobe phase, in which the read or write strobe is raised and the data moves across the bus. A hold phase closes the cycle. Throughout the cycle, the lowest address bits are driven on a separate `addr_lo` output.

The controller remembers which 16-byte block it last latched for code. A sequential code fetch that stays inside that block skips the address-latch phase. A fetch outside that block, the first fetch after a change of program flow, and the first fetch after any data access all latch again. The bus can be set to half width. In that mode each 16-bit transfer becomes two byte cycles, with the low byte first. The external `wait_in` input stretches any strobe phase for as long as it is held.

The block accepts a request in the cycle where `req_ready` and `req_valid` are both high. It then pulses `done` once the transfer has finished.

Top module: `xbus_cycle_ctl`

## Requirements
- R1: During and after reset, `ale`, `rd_stb`, `wr_stb`, `done` and `bus_oe` are low and `req_ready` is high. The latched-block record is invalid.
- R2: A code fetch that arrives with no valid latched block, or with `req_flow` high, gets an address-latch phase. During that phase `bus_oe` is high and `bus_out` carries the request address with bit 0 cleared.
- R3: A code fetch without `req_flow`, whose address bits [AW-1:4] equal the latched block, gets no address-latch phase.
- R4: A code fetch whose address bits [AW-1:4] differ from the latched block gets an address-latch phase. That block then becomes the latched block.
- R5: The first code fetch after any data access gets an address-latch phase.
- R6: Every data access, whether read or write, gets an address-latch phase.
- R7: When `cfg_bus8` is 0 at acceptance, a transfer is one strobe cycle. A read returns `bus_in[15:0]` on `rdata`. A write drives `req_wdata` on `bus_out`.
- R8: When `cfg_bus8` is 1 at acceptance, a transfer is two strobe cycles. The even byte (`rdata[7:0]` or `req_wdata[7:0]`) goes first and the odd byte second, both on bus bits [7:0], and `bus_in[15:8]` is ignored. Only the first byte cycle can have an address-latch phase.
- R9: `wait_in` is sampled at the end of each strobe phase. Each clock in which it is high extends the strobe by one clock, with the address and strobes unchanged. In any other phase it has no effect.
- R10: The address-latch, strobe and hold phases each last one clock. `done` is high during the final hold phase. The latency counted from acceptance is bytes × (2 + waits) + (1 if latched). `req_ready` is high only when the block is idle.
- R11: During a strobe phase, `addr_lo` carries the low four bits of the byte cycle address, whose bit 0 is the byte index. Bit 0 of `req_addr` is ignored.
- R12: `rd_stb` and `wr_stb` are never high together. `wr_stb` occurs only for data writes, so `req_write` is ignored on code fetches. `bus_oe` is low during a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_is_data | input | 1 | 1 = data access, 0 = code fetch |
| req_write | input | 1 | Write (data accesses only) |
| req_flow | input | 1 | Code fetch follows a program flow change |
| req_addr | input | AW | Byte address (bit 0 ignored) |
| req_wdata | input | AW | Write data |
| cfg_bus8 | input | 1 | Half-width bus mode, sampled at acceptance |
| wait_in | input | 1 | Strobe extension request |
| ale | output | 1 | Address latch strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| addr_lo | output | 4 | Low address bits of the current byte cycle |
| bus_out | output | AW | Multiplexed bus, outgoing value |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | AW | Multiplexed bus, incoming value |
| rdata | output | AW | Read data, valid with `done` |
| done | output | 1 | Transfer finished |

## Verification
On every cycle, the assertions check the order of the phases: the latch phase is followed by the strobe, and a strobe that ends is followed by the hold. They also check that a waited strobe keeps its address and direction, that the two strobes are exclusive, that the bus is released during reads, and that the controller is quiet while idle. Whether a given request should have latched depends on the history of earlier blocks, flow changes and data accesses. That decision, together with the byte order and the data content, can only be shown by the bench's scenarios. The bench does this through a memory model that rebuilds each address from the latched upper bits and `addr_lo`.

// File: rtl/xbus_cycle_ctl.sv
module xbus_cycle_ctl #(
  parameter int AW    = 16,
  parameter int BLK_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_is_data,
  input  logic          req_write,
  input  logic          req_flow,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_wdata,
  input  logic          cfg_bus8,
  input  logic          wait_in,
  output logic          ale,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [BLK_W-1:0] addr_lo,
  output logic [AW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [AW-1:0] bus_in,
  output logic [AW-1:0] rdata,
  output logic          done
);
  localparam int HW   = AW / 2;
  localparam int HI_W = AW - BLK_W;

  typedef enum logic [1:0] {S_IDLE, S_ALE, S_STRB, S_HOLD} state_t;

  state_t          state_q;
  logic [AW-1:0]   addr_q, wdata_q, rdata_q;
  logic            data_q, wr_q, bus8_q, byte_q;
  logic            lat_valid_q;
  logic [HI_W-1:0] lat_blk_q;

  wire [AW-1:0] cur_addr = {addr_q[AW-1:1], byte_q};
  wire          last     = !bus8_q || byte_q;
  wire          hit      = lat_valid_q && (lat_blk_q == req_addr[AW-1:BLK_W]);
  wire          need_ale = req_is_data || req_flow || !hit;
  wire          strobe   = (state_q == S_STRB);

  assign req_ready = (state_q == S_IDLE);
  assign ale       = (state_q == S_ALE);
  assign rd_stb    = strobe && !wr_q;
  assign wr_stb    = strobe && wr_q;
  assign done      = (state_q == S_HOLD) && last;
  assign addr_lo   = cur_addr[BLK_W-1:0];
  assign bus_oe    = ale || wr_stb;
  assign rdata     = rdata_q;

  always_comb begin
    bus_out = '0;
    if (ale)
      bus_out = cur_addr;
    else if (wr_stb)
      bus_out = !bus8_q ? wdata_q
              : {{(AW-HW){1'b0}}, (byte_q ? wdata_q[AW-1:HW] : wdata_q[HW-1:0])};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      data_q      <= 1'b0;
      wr_q        <= 1'b0;
      bus8_q      <= 1'b0;
      byte_q      <= 1'b0;
      lat_valid_q <= 1'b0;
      lat_blk_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          addr_q  <= {req_addr[AW-1:1], 1'b0};
          wdata_q <= req_wdata;
          data_q  <= req_is_data;
          wr_q    <= req_is_data && req_write;
          bus8_q  <= cfg_bus8;
          byte_q  <= 1'b0;
          if (req_is_data || req_flow) lat_valid_q <= 1'b0;
          state_q <= need_ale ? S_ALE : S_STRB;
        end
        S_ALE: begin
          if (!data_q) begin
            lat_valid_q <= 1'b1;
            lat_blk_q   <= addr_q[AW-1:BLK_W];
          end
          state_q <= S_STRB;
        end
        S_STRB: if (!wait_in) begin
          if (!bus8_q)     rdata_q            <= bus_in;
          else if (byte_q) rdata_q[AW-1:HW]   <= bus_in[HW-1:0];
          else             rdata_q[HW-1:0]    <= bus_in[HW-1:0];
          state_q <= S_HOLD;
        end
        S_HOLD: begin
          if (last) state_q <= S_IDLE;
          else begin
            byte_q  <= 1'b1;
            state_q <= S_STRB;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_cycle_ctl_chk.sv
module xbus_cycle_ctl_chk #(
  parameter int BLK_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             ale,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic             bus_oe,
  input logic             wait_in,
  input logic             done,
  input logic [BLK_W-1:0] addr_lo
);
  wire stb = rd_stb || wr_stb;

  p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && !stb && !done));

  p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (bus_oe && !stb));

  p_ale_to_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (stb && !ale));

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && wait_in) |=> (stb && $stable(addr_lo) && $stable(wr_stb)));

  p_strobe_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !wait_in) |=> (!stb && !ale));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  p_read_float_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !bus_oe);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
endmodule

bind xbus_cycle_ctl xbus_cycle_ctl_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ale(ale),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_oe(bus_oe), .wait_in(wait_in),
  .done(done), .addr_lo(addr_lo)
);

// File: tb/xbus_cycle_ctl_tb_top.sv
module xbus_cycle_ctl_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_is_data = 0, req_write = 0, req_flow = 0, cfg_bus8 = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, bus_in = 0;
  logic        wait_in = 0;
  logic        req_ready, ale, rd_stb, wr_stb, bus_oe, done;
  logic [3:0]  addr_lo;
  logic [15:0] bus_out, rdata;

  xbus_cycle_ctl #(.AW(16), .BLK_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_write(req_write), .req_flow(req_flow),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_bus8(cfg_bus8),
    .wait_in(wait_in), .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr_lo(addr_lo), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .rdata(rdata), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic [7:0] memb(input [15:0] a);
    return (a[7:0] * 8'd7) ^ (a[15:8] + 8'h11);
  endfunction

  // Behavioural external memory and bus monitor
  int          cur_waits = 0, wcnt = 0;
  int          n_ale = 0, n_rd = 0, n_wr = 0, ncyc = 0;
  logic [11:0] lat_hi_m = 0;
  logic [15:0] ale_addr = 0;
  logic [15:0] cyc_addr [0:3];
  logic [15:0] cyc_data [0:3];

  always @(negedge clk) begin
    if (ale) begin
      n_ale++;
      ale_addr = bus_out;
      lat_hi_m = bus_out[15:4];
    end
    if (rd_stb || wr_stb) begin
      logic [15:0] a;
      a = {lat_hi_m, addr_lo};
      bus_in = dut_i.bus8_q ? 16'h0 : 16'h0;
      bus_in = cfg_bus8 ? {8'hA5, memb(a)} : {memb(a | 16'h1), memb(a)};
      if (wcnt > 0) begin
        wait_in = 1'b1;
        wcnt--;
      end else begin
        wait_in = 1'b0;
        if (ncyc < 4) begin
          cyc_addr[ncyc] = a;
          cyc_data[ncyc] = bus_out;
        end
        ncyc++;
        if (rd_stb) n_rd++;
        if (wr_stb) n_wr++;
      end
    end else begin
      wcnt    = cur_waits;
      wait_in = 1'($urandom % 2);
    end
  end

  // Bench reference of the latched block
  bit          m_lv = 0;
  logic [11:0] m_blk = 0;

  task automatic txn(input bit is_data, input bit wr, input bit flow,
                     input [15:0] addr, input [15:0] wd, input bit b8, input int w);
    bit exp_ale;
    int nb, lat, k;
    logic [15:0] ea;
    string why;
    exp_ale = is_data || flow || !m_lv || (m_blk != addr[15:4]);
    why = is_data ? "R6" : (!m_lv ? (flow ? "R2" : "R5/R2") : (flow ? "R2" :
          (m_blk != addr[15:4] ? "R4" : "R3")));
    nb  = b8 ? 2 : 1;
    lat = nb * (2 + w) + (exp_ale ? 1 : 0);
    ea  = {addr[15:1], 1'b0};
    @(posedge clk);
    cur_waits = w;
    @(negedge clk);
    n_ale = 0; n_rd = 0; n_wr = 0; ncyc = 0;
    chk(req_ready, "R10 ready idle", int'(req_ready), 1);
    req_valid = 1; req_is_data = is_data; req_write = wr; req_flow = flow;
    req_addr = addr; req_wdata = wd; cfg_bus8 = b8;
    @(negedge clk);
    req_valid = 0;
    k = 1;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(k == lat, "R10/R9 latency", k, lat);
    chk(n_ale == (exp_ale ? 1 : 0), {why, " latch phase count"}, n_ale, exp_ale ? 1 : 0);
    if (exp_ale) chk(ale_addr == ea, "R2 latched address", ale_addr, ea);
    chk(ncyc == nb, b8 ? "R8 byte cycles" : "R7 strobe cycles", ncyc, nb);
    for (int b = 0; b < nb && b < 4; b++)
      chk(cyc_addr[b] == (ea | 16'(b)), "R11 cycle address", cyc_addr[b], ea | 16'(b));
    if (is_data && wr) begin
      chk(n_rd == 0, "R12 no read on write", n_rd, 0);
      if (!b8) chk(cyc_data[0] == wd, "R7 write word", cyc_data[0], wd);
      else begin
        chk(cyc_data[0][7:0] == wd[7:0], "R8 write low byte first", cyc_data[0][7:0], wd[7:0]);
        chk(cyc_data[1][7:0] == wd[15:8], "R8 write high byte", cyc_data[1][7:0], wd[15:8]);
      end
    end else begin
      chk(n_wr == 0, "R12 no write strobe", n_wr, 0);
      chk(rdata == {memb(ea | 16'h1), memb(ea)}, b8 ? "R8 read data" : "R7 read data",
          rdata, {memb(ea | 16'h1), memb(ea)});
    end
    if (is_data) m_lv = 0;
    else if (exp_ale) begin m_lv = 1; m_blk = addr[15:4]; end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!ale && !rd_stb && !wr_stb && !done && !bus_oe && req_ready, "R1 reset outputs",
        {ale, rd_stb, wr_stb, done, bus_oe, req_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    chk(!ale && !rd_stb && !wr_stb && !done && req_ready, "R1 after reset",
        {ale, rd_stb, wr_stb, done, req_ready}, 1);
    txn(0, 0, 0, 16'h1230, 0, 0, 0);        // R2 first fetch
    txn(0, 0, 0, 16'h1232, 0, 0, 0);        // R3
    txn(0, 0, 0, 16'h123E, 0, 0, 1);        // R3 with wait
    txn(0, 0, 0, 16'h1240, 0, 0, 0);        // R4 boundary
    txn(0, 0, 1, 16'h1242, 0, 0, 0);        // R2 flow change
    txn(1, 0, 0, 16'h8000, 0, 0, 0);        // R6 data read
    txn(0, 0, 0, 16'h1244, 0, 0, 0);        // R5 after data
    txn(0, 0, 0, 16'h1246, 0, 1, 2);        // R8 R9
    txn(1, 1, 0, 16'h4321, 16'hBEEF, 1, 1); // R8 R11 R12 write
    txn(0, 1, 0, 16'h1249, 0, 0, 3);        // R5 R12 code with write flag
    txn(1, 1, 0, 16'h0102, 16'hC0DE, 0, 0); // R7 word write
    begin
      logic [15:0] pa;
      pa = 16'h1249;
      for (int i = 0; i < 80; i++) begin
        bit d, f, b8;
        logic [15:0] a;
        d  = ($urandom % 4) == 0;
        f  = ($urandom % 6) == 0;
        b8 = ($urandom % 2) == 1;
        a  = (($urandom % 3) != 0) ? pa + 16'd2 : 16'($urandom);
        txn(d, 1'($urandom % 2), f, a, 16'($urandom), b8, int'($urandom % 4));
        if (!d) pa = a;
      end
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule